// File: doc/BRIEF.md
# Atomic Wide-Register Byte Bridge

This block sits between an 8-bit processor data bus and a group of 16-bit timer registers: one free-running counter and a parameterised number of compare values. The 8-bit bus cannot move a 16-bit value in one access, so the block holds a single staging byte. All the wide registers share this one byte, so the two halves of any 16-bit value always move together.

On a write, software first writes the high-byte address. That byte goes only into the staging byte. The following low-byte write then delivers the staging byte and the new low byte to the target in one step. For the counter, the block raises a one-cycle load pulse with the 16-bit value, and the external timer takes it. The compare values are stored inside the block and driven out in parallel.

On a read, a low-byte read of the counter returns the live low byte and, in the same cycle, captures the live high byte into the staging byte. A later high-byte read of the counter returns that captured byte. The compare values cannot change on their own, so both of their bytes are read directly and the staging byte is left alone. The staging byte is shared, so interleaved accesses to different registers act on one another, and the block keeps this behaviour deliberately.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the read data, the compare outputs, the counter load pulse, the counter load value and the staging byte are all zero. A counter high-byte read as the first access returns 0.
- R2: A write to a high-byte address (address bit 0 = 1; address bits above bit 0 select the register: 0 = counter, 1 = compare A, 2 = compare B) changes only the staging byte. No target changes and no load pulse is raised.
- R3: A write to the counter low byte (address 0) raises `cnt_load` for exactly the next cycle, with `cnt_load_val` = {staging byte, written byte}. `cnt_load_val` holds its value afterwards.
- R4: A write to a compare low byte (address 2 or 4) updates all 16 bits of that compare output on the next cycle to {staging byte, written byte}. Compare outputs change only on such a write.
- R5: A counter low-byte read returns the live low byte on `bus_rdata` one cycle later and captures the live high byte into the staging byte. A later counter high-byte read returns the captured byte, even if the live counter has since changed.
- R6: Compare reads (addresses 2 to 5) return the stored low or high byte one cycle later and leave the staging byte unchanged.
- R7: The staging byte is shared. A low-byte write to one register after a high-byte write to another register uses that other register's high byte. A counter low-byte read between a high-byte write and a low-byte write replaces the staged byte.
- R8: Addresses whose register index is 3 or more (addresses 6 and 7) are unmapped. Writes to them change nothing, including the staging byte. Reads from them return 0.
- R9: When write and read strobes are both high in one cycle, only the write is carried out and `bus_rdata` keeps its previous value.
- R10: `bus_rdata` keeps its value in every cycle without a performed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address: bit 0 selects the high byte, the upper bits select the register |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read |
| cnt_live | input | 16 | Live counter value from the timer |
| cnt_load | output | 1 | One-cycle pulse: load the counter with cnt_load_val |
| cnt_load_val | output | 16 | 16-bit value for the counter load |
| cmp_vals | output | NUM_CMP*16 | Compare values, compare A in the low 16 bits |

## Verification
The main path is tried with three kinds of patterns. Clean pairs (high byte then low byte to the same register) show that both bytes land together. Interleaved pairs, where a different register's high write or a counter low read falls between the two halves, show that the staging byte really is shared and not kept per register. Counter read pairs, with the live value changed between the low and high reads, tell a snapshot apart from a live pass-through. Compare reads after counter captures show that the compare path bypasses the staging byte. Unmapped, simultaneous-strobe and idle cycles show that only performed accesses touch any state.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] word,
                                                  input logic               upper);
    return upper ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 3,
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [IDX_W-1:0]  idx,
  output logic              mapped,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic              rd_hi,
  output logic              rd_lo,
  output logic              rd_any
);
  localparam logic [IDX_W:0] REG_LIMIT = (IDX_W + 1)'(NUM_REGS);

  logic upper;
  logic rd_eff;

  always_comb begin
    idx    = addr[ADDR_W-1:1];
    upper  = addr[0];
    mapped = ({1'b0, idx} < REG_LIMIT);
    // write wins over a read issued in the same cycle
    rd_eff = rd & ~wr;
    wr_hi  = wr & mapped & upper;
    wr_lo  = wr & mapped & ~upper;
    rd_hi  = rd_eff & mapped & upper;
    rd_lo  = rd_eff & mapped & ~upper;
    rd_any = rd_eff;
  end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp
  import wrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              stage_cap,
  input  logic [BYTE_W-1:0] live_hi,
  output logic [BYTE_W-1:0] temp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else if (stage_wr) begin
      temp_q <= wdata;
    end else if (stage_cap) begin
      temp_q <= live_hi;
    end
  end
endmodule

// File: rtl/wrb_cmp_bank.sv
module wrb_cmp_bank
  import wrb_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_lo,
  input  logic [IDX_W-1:0]          idx,
  input  logic [BYTE_W-1:0]         temp_q,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [NUM_CMP*WORD_W-1:0] vals
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i + 1);
    logic [WORD_W-1:0] val_q;
    logic              hit;

    assign hit = wr_lo & (idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= join_bytes(temp_q, wdata);
      end
    end

    assign vals[i*WORD_W +: WORD_W] = val_q;
  end
endmodule

// File: rtl/wrb_read_mux.sv
module wrb_read_mux
  import wrb_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_any,
  input  logic                      rd_hi,
  input  logic                      rd_lo,
  input  logic [IDX_W-1:0]          idx,
  input  logic [BYTE_W-1:0]         temp_q,
  input  logic [WORD_W-1:0]         cnt_live,
  input  logic [NUM_CMP*WORD_W-1:0] cmp_vals,
  output logic [BYTE_W-1:0]         rdata
);
  logic [BYTE_W-1:0] sel_byte;
  logic              is_cnt;

  always_comb begin
    is_cnt   = (idx == '0);
    sel_byte = '0;
    if (is_cnt) begin
      if (rd_lo)      sel_byte = cnt_live[BYTE_W-1:0];
      else if (rd_hi) sel_byte = temp_q;
    end else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if ((rd_lo | rd_hi) && idx == IDX_W'(i + 1)) begin
          sel_byte = pick_byte(cmp_vals[i*WORD_W +: WORD_W], rd_hi);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_any) begin
      rdata <= sel_byte;
    end
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_CMP = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  output logic [BYTE_W-1:0]         bus_rdata,
  input  logic [WORD_W-1:0]         cnt_live,
  output logic                      cnt_load,
  output logic [WORD_W-1:0]         cnt_load_val,
  output logic [NUM_CMP*WORD_W-1:0] cmp_vals
);
  localparam int IDX_W    = ADDR_W - 1;
  localparam int NUM_REGS = NUM_CMP + 1;

  logic [IDX_W-1:0]  acc_idx;
  logic              addr_mapped;
  logic              dec_wr_hi, dec_wr_lo, dec_rd_hi, dec_rd_lo;
  logic              ev_rd_any;
  logic              ev_wr_hi;
  logic              ev_wr_lo_cnt, ev_wr_lo_cmp;
  logic              ev_rd_lo_cnt, ev_rd_cmp;
  logic [BYTE_W-1:0] temp_q;

  wrb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .idx(acc_idx), .mapped(addr_mapped),
    .wr_hi(dec_wr_hi), .wr_lo(dec_wr_lo),
    .rd_hi(dec_rd_hi), .rd_lo(dec_rd_lo), .rd_any(ev_rd_any)
  );

  // named events for the checker
  assign ev_wr_hi     = dec_wr_hi;
  assign ev_wr_lo_cnt = dec_wr_lo & (acc_idx == '0);
  assign ev_wr_lo_cmp = dec_wr_lo & (acc_idx != '0);
  assign ev_rd_lo_cnt = dec_rd_lo & (acc_idx == '0);
  assign ev_rd_cmp    = (dec_rd_lo | dec_rd_hi) & (acc_idx != '0);

  wrb_temp u_temp (
    .clk(clk), .rst_n(rst_n),
    .stage_wr(ev_wr_hi), .wdata(bus_wdata),
    .stage_cap(ev_rd_lo_cnt), .live_hi(cnt_live[WORD_W-1:BYTE_W]),
    .temp_q(temp_q)
  );

  wrb_cmp_bank #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(dec_wr_lo), .idx(acc_idx),
    .temp_q(temp_q), .wdata(bus_wdata),
    .vals(cmp_vals)
  );

  wrb_read_mux #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_any(ev_rd_any), .rd_hi(dec_rd_hi), .rd_lo(dec_rd_lo),
    .idx(acc_idx), .temp_q(temp_q),
    .cnt_live(cnt_live), .cmp_vals(cmp_vals),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_load     <= 1'b0;
      cnt_load_val <= '0;
    end else begin
      cnt_load <= ev_wr_lo_cnt;
      if (ev_wr_lo_cnt) begin
        cnt_load_val <= join_bytes(temp_q, bus_wdata);
      end
    end
  end
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int NUM_CMP = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            bus_wdata,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [7:0]            bus_rdata,
  input logic [15:0]           cnt_live,
  input logic                  cnt_load,
  input logic [15:0]           cnt_load_val,
  input logic [NUM_CMP*16-1:0] cmp_vals,
  input logic                  addr_mapped,
  input logic                  ev_wr_hi,
  input logic                  ev_wr_lo_cnt,
  input logic                  ev_wr_lo_cmp,
  input logic                  ev_rd_lo_cnt,
  input logic                  ev_rd_cmp,
  input logic                  ev_rd_any,
  input logic [7:0]            temp_q
);
  AST_HI_WR_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hi |=> temp_q == $past(bus_wdata)); // R2
  AST_HI_WR_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hi |=> !cnt_load && $stable(cmp_vals)); // R2
  AST_CNT_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_lo_cnt |=> cnt_load && cnt_load_val == {$past(temp_q), $past(bus_wdata)}); // R3
  AST_CNT_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr_lo_cnt |=> !cnt_load && $stable(cnt_load_val)); // R3
  AST_CMP_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr_lo_cmp |=> $stable(cmp_vals)); // R4
  AST_CNT_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_lo_cnt |=> bus_rdata == $past(cnt_live[7:0]) && temp_q == $past(cnt_live[15:8])); // R5
  AST_CMP_RD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_cmp |=> $stable(temp_q)); // R6
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !addr_mapped) |=> bus_rdata == 8'h00); // R8
  AST_UNMAPPED_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !addr_mapped) |=> $stable(temp_q) && $stable(cmp_vals) && !cnt_load); // R8
  AST_BOTH_STROBES_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> $stable(bus_rdata)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd_any |=> $stable(bus_rdata)); // R10
endmodule

bind wide_reg_bridge wrb_checker #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .cnt_live(cnt_live),
  .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cmp_vals(cmp_vals),
  .addr_mapped(addr_mapped),
  .ev_wr_hi(ev_wr_hi), .ev_wr_lo_cnt(ev_wr_lo_cnt), .ev_wr_lo_cmp(ev_wr_lo_cmp),
  .ev_rd_lo_cnt(ev_rd_lo_cnt), .ev_rd_cmp(ev_rd_cmp), .ev_rd_any(ev_rd_any),
  .temp_q(temp_q)
);

// File: tb/wide_reg_bridge_tb.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_live = '0;
  logic        cnt_load;
  logic [15:0] cnt_load_val;
  logic [31:0] cmp_vals;

  always #2 clk = ~clk;

  wide_reg_bridge #(.ADDR_W(3), .NUM_CMP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt_live(cnt_live), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .cmp_vals(cmp_vals)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    int          kind;   // 0 rdata, 1 load flag, 2 load value, 3 cmp A, 4 cmp B
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // independent model
  logic [7:0]  m_stage = '0;
  logic [7:0]  m_rd = '0;
  logic [15:0] m_cmp_a = '0;
  logic [15:0] m_cmp_b = '0;
  logic [15:0] m_load_val = '0;
  logic [15:0] m_live = '0;

  task automatic push(input int k, input logic [15:0] v, input string r);
    item_t it;
    it.at = cyc + 1; it.kind = k; it.exp = v; it.req = r;
    sbq.push_back(it);
  endtask

  task automatic bus_op(input bit w, input bit r, input logic [2:0] a,
                        input logic [7:0] d, input string tag);
    bit ld;
    int reg_no;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; cnt_live = m_live;
    ld = 1'b0;
    reg_no = a / 2;
    if (w) begin
      if (reg_no <= 2) begin
        if (a % 2 == 1) m_stage = d;
        else if (reg_no == 0) begin ld = 1'b1; m_load_val = m_stage * 256 + d; end
        else if (reg_no == 1) m_cmp_a = m_stage * 256 + d;
        else m_cmp_b = m_stage * 256 + d;
      end
    end else if (r) begin
      case (a)
        3'd0: begin m_rd = m_live % 256; m_stage = m_live / 256; end
        3'd1: m_rd = m_stage;
        3'd2: m_rd = m_cmp_a % 256;
        3'd3: m_rd = m_cmp_a / 256;
        3'd4: m_rd = m_cmp_b % 256;
        3'd5: m_rd = m_cmp_b / 256;
        default: m_rd = 8'h00;
      endcase
    end
    push(0, {8'h00, m_rd}, tag);
    push(1, {15'd0, ld}, tag);
    push(2, m_load_val, tag);
    push(3, m_cmp_a, tag);
    push(4, m_cmp_b, tag);
  endtask

  task automatic idle(input string tag);
    bus_op(1'b0, 1'b0, 3'd0, 8'h00, tag);
  endtask

  // monitor
  always begin
    item_t it;
    logic [15:0] act;
    @(negedge clk);
    while (sbq.size() > 0 && sbq[0].at == cyc) begin
      it = sbq.pop_front();
      case (it.kind)
        0: act = {8'h00, bus_rdata};
        1: act = {15'd0, cnt_load};
        2: act = cnt_load_val;
        3: act = cmp_vals[15:0];
        default: act = cmp_vals[31:16];
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic direct_check(input logic [15:0] act, input logic [15:0] exp, input string r);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    direct_check({8'h00, bus_rdata}, 16'h0000, "R1 rdata");
    direct_check(cmp_vals[15:0], 16'h0000, "R1 cmp A");
    direct_check(cmp_vals[31:16], 16'h0000, "R1 cmp B");
    direct_check({15'd0, cnt_load}, 16'h0000, "R1 load pulse");
    direct_check(cnt_load_val, 16'h0000, "R1 load value");
    bus_op(1'b0, 1'b1, 3'd1, 8'h00, "R1 staging byte reads zero");

    // R2 and R3: counter write pair
    bus_op(1'b1, 1'b0, 3'd1, 8'hC3, "R2 hi write stages only");
    bus_op(1'b1, 1'b0, 3'd0, 8'h5E, "R3 counter load C35E");
    idle("R3 pulse ends");
    // R4: compare A and B clean pairs
    bus_op(1'b1, 1'b0, 3'd3, 8'h12, "R2 hi write stages only");
    bus_op(1'b1, 1'b0, 3'd2, 8'h34, "R4 cmp A 1234");
    bus_op(1'b1, 1'b0, 3'd5, 8'hAB, "R2 hi write stages only");
    bus_op(1'b1, 1'b0, 3'd4, 8'hCD, "R4 cmp B ABCD");
    // R5: snapshot versus live
    m_live = 16'h1234;
    bus_op(1'b0, 1'b1, 3'd0, 8'h00, "R5 counter low read");
    m_live = 16'hFEDC;
    bus_op(1'b0, 1'b1, 3'd1, 8'h00, "R5 counter high read is snapshot");
    // R6: compare reads bypass staging
    bus_op(1'b0, 1'b1, 3'd3, 8'h00, "R6 cmp A high read");
    bus_op(1'b0, 1'b1, 3'd4, 8'h00, "R6 cmp B low read");
    bus_op(1'b0, 1'b1, 3'd1, 8'h00, "R6 staging untouched by cmp reads");
    // R7: shared staging byte
    bus_op(1'b1, 1'b0, 3'd3, 8'h5A, "R7 hi write for cmp A");
    bus_op(1'b1, 1'b0, 3'd4, 8'h77, "R7 cmp B gets stale high 5A77");
    bus_op(1'b1, 1'b0, 3'd1, 8'h11, "R7 hi write for counter");
    m_live = 16'h9988;
    bus_op(1'b0, 1'b1, 3'd0, 8'h00, "R7 counter read replaces staging");
    bus_op(1'b1, 1'b0, 3'd2, 8'h22, "R7 cmp A gets 9922");
    bus_op(1'b1, 1'b0, 3'd0, 8'h01, "R7 counter load 9901");
    // R8: unmapped addresses
    bus_op(1'b1, 1'b0, 3'd3, 8'h42, "R2 hi write stages only");
    bus_op(1'b1, 1'b0, 3'd7, 8'hEE, "R8 unmapped hi write inert");
    bus_op(1'b1, 1'b0, 3'd6, 8'hEF, "R8 unmapped lo write inert");
    bus_op(1'b0, 1'b1, 3'd1, 8'h00, "R8 staging kept 42");
    bus_op(1'b0, 1'b1, 3'd6, 8'h00, "R8 unmapped read zero");
    bus_op(1'b0, 1'b1, 3'd2, 8'h00, "R6 cmp A low read");
    // R9: both strobes, write wins
    bus_op(1'b1, 1'b1, 3'd0, 8'h99, "R9 write done, read dropped");
    bus_op(1'b1, 1'b1, 3'd3, 8'h07, "R9 hi write with read strobe");
    bus_op(1'b0, 1'b1, 3'd1, 8'h00, "R9 staging shows 07");
    // R10: holds over idle cycles
    idle("R10 rdata hold");
    idle("R10 rdata hold");
    idle("R10 rdata hold");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule